// File: doc/BRIEF.md
# Nine-bit serial command transmitter

The block sends one panel command over a three-wire serial link (active-low select, clock, data) in which every word is nine bits long. The leading bit of each word tells the panel what kind of word it is: a cleared leading bit marks the opcode word, and a set leading bit marks a parameter byte. One transaction is the opcode word followed by a given number of parameter words, all sent under a single select window. The number of parameter words may be zero.

A client presents an 8-bit opcode and a parameter count with a valid/ready handshake. While the block shifts words out, it requests each parameter byte in turn on a second valid/ready port. The serial clock is derived from the system clock by a parameterized half-period divider. With the default of 125 system cycles per half period and a 250 MHz system clock, the serial clock runs at 1 MHz. A one-cycle done pulse marks the end of each transaction.

Top module: `nine_bit_cmd_tx`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, done_o is 0, cmd_ready_o is 1 and par_ready_o is 0.
- R2: The first word of a transaction is nine bits: a 0 followed by the opcode, most significant bit first.
- R3: Each parameter word is nine bits: a 1 followed by the byte, most significant bit first. Exactly cmd_count_i parameter words follow the opcode word, in the order the bytes were accepted.
- R4: With a count of zero, only the opcode word is sent, which gives exactly nine rising serial clock edges.
- R5: The serial clock idles low while cs_no is high, and sdo_o changes only while sclk_o is low, so the panel can sample on the rising edge.
- R6: Within a word, rising serial clock edges are exactly 2*HALF_DIV system cycles apart, and every high phase lasts exactly HALF_DIV cycles (1 MHz at 250 MHz with the defaults).
- R7: cs_no falls once per transaction, stays low across all words, and rises only after the last bit. A transaction of N parameters gives 9*(N+1) rising clock edges.
- R8: cmd_ready_o is 0 from acceptance until the transaction ends. A cmd_valid_i raised while busy is ignored and starts no further transaction.
- R9: done_o is high for exactly one cycle. It rises in the same cycle that cs_no returns high and sclk_o is low, and cmd_ready_o returns to 1 in the following cycle.
- R10: par_ready_o is 1 only between words while a parameter is still owed. While the byte is withheld, sclk_o stays low and cs_no stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Opcode and count are valid |
| cmd_ready_o | output | 1 | Block is idle and takes a command |
| cmd_code_i | input | DATA_W | Opcode byte |
| cmd_count_i | input | CNT_W | Number of parameter bytes to send |
| par_valid_i | input | 1 | Parameter byte is valid |
| par_ready_o | output | 1 | Block takes the next parameter byte |
| par_data_i | input | DATA_W | Parameter byte |
| cs_no | output | 1 | Panel select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial data, most significant bit first |
| done_o | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
The opcode is accepted on the edge where cmd_valid_i and cmd_ready_o are both high. Select falls on that edge, and the first rising serial clock edge follows HALF_DIV cycles later. Each later edge follows after another HALF_DIV cycles, except at a word boundary, where the low phase is stretched by the parameter handshake. All outputs are registered from the next state, so done_o, the rise of cs_no and the final fall of sclk_o appear on the same edge, and cmd_ready_o comes back one cycle later. The bench drives inputs just after a rising edge and samples every output on the falling edge. A serial monitor rebuilds the words from sdo_o at each observed rising sclk_o and times the edges in system cycles. The done-time checks are made at the first falling edge where done_o is seen and at the falling edge after it.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_FETCH,
    ST_DONE
  } nbt_state_e;
endpackage

// File: rtl/nbt_clk_div.sv
module nbt_clk_div #(
  parameter int HALF_DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  // restart from zero whenever stopped so each phase is full length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nbt_shift.sv
module nbt_shift #(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              shift_i,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (load_i)   sh_q <= load_word_i;
    else if (shift_i)  sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign sdo_o = sh_q[WORD_W-1];

  // R5
  load_shift_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i))
    else $error("load and shift in same cycle");
endmodule

// File: rtl/nbt_ctrl.sv
module nbt_ctrl
  import nbt_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int HALF_DIV = 125
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [DATA_W-1:0] cmd_code_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic              par_valid_i,
  output logic              par_ready_o,
  input  logic [DATA_W-1:0] par_data_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic              load_o,
  output logic [DATA_W:0]   load_word_o,
  output logic              shift_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              done_o
);
  localparam int WORD_W = DATA_W + 1;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  nbt_state_e       state_q, state_d;
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] rem_q;
  logic             sclk_q, cs_q, done_q;

  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    load_word_o = '0;
    shift_o     = 1'b0;
    run_o       = 1'b0;
    cmd_ready_o = 1'b0;
    par_ready_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cmd_ready_o = 1'b1;
        if (cmd_valid_i) begin
          load_o      = 1'b1;
          load_word_o = {1'b0, cmd_code_i};
          state_d     = ST_LOW;
        end
      end
      ST_LOW: begin
        run_o = 1'b1;
        if (tick_i) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        run_o = 1'b1;
        if (tick_i) begin
          if (bit_q == LAST_BIT) begin
            state_d = (rem_q != '0) ? ST_FETCH : ST_DONE;
          end else begin
            shift_o = 1'b1;
            state_d = ST_LOW;
          end
        end
      end
      ST_FETCH: begin
        par_ready_o = 1'b1;
        if (par_valid_i) begin
          load_o      = 1'b1;
          load_word_o = {1'b1, par_data_i};
          state_d     = ST_LOW;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rem_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o)       bit_q <= '0;
      else if (shift_o) bit_q <= bit_q + 1'b1;
      if (state_q == ST_IDLE && cmd_valid_i)        rem_q <= cmd_count_i;
      else if (state_q == ST_FETCH && par_valid_i)  rem_q <= rem_q - 1'b1;
      // outputs registered from next state: glitch-free and edge aligned
      sclk_q <= (state_d == ST_HIGH);
      cs_q   <= !(state_d inside {ST_LOW, ST_HIGH, ST_FETCH});
      done_q <= (state_d == ST_DONE);
    end
  end

  assign sclk_o = sclk_q;
  assign cs_no  = cs_q;
  assign done_o = done_q;

  // high-phase width monitor
  localparam int HC_W = $clog2(HALF_DIV + 2);
  logic [HC_W-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_cnt_q <= '0;
    else if (sclk_q)  hi_cnt_q <= hi_cnt_q + 1'b1;
    else              hi_cnt_q <= '0;
  end

  // R8
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !cmd_ready_o)
    else $error("ready while busy");

  // R5
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o)
    else $error("clock active while deselected");

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done wider than one cycle");

  // R9
  done_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && $past(!cs_no)))
    else $error("done not aligned with select release");

  // R10
  par_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_ready_o |-> (!cs_no && !sclk_o))
    else $error("parameter request outside low phase");

  // R6
  high_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (hi_cnt_q == HC_W'(HALF_DIV)))
    else $error("clock high phase wrong length");
endmodule

// File: rtl/nine_bit_cmd_tx.sv
module nine_bit_cmd_tx #(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int HALF_DIV = 125
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [DATA_W-1:0] cmd_code_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic              par_valid_i,
  output logic              par_ready_o,
  input  logic [DATA_W-1:0] par_data_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              done_o
);
  localparam int WORD_W = DATA_W + 1;

  logic              run, tick, load, shift;
  logic [WORD_W-1:0] load_word;

  nbt_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  nbt_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HALF_DIV(HALF_DIV)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_code_i  (cmd_code_i),
    .cmd_count_i (cmd_count_i),
    .par_valid_i (par_valid_i),
    .par_ready_o (par_ready_o),
    .par_data_i  (par_data_i),
    .tick_i      (tick),
    .run_o       (run),
    .load_o      (load),
    .load_word_o (load_word),
    .shift_o     (shift),
    .sclk_o      (sclk_o),
    .cs_no       (cs_no),
    .done_o      (done_o)
  );

  nbt_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_word_i (load_word),
    .shift_i     (shift),
    .sdo_o       (sdo_o)
  );

  // R5
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o))
    else $error("data moved while clock high");
endmodule

// File: tb/sim_nine_bit_cmd_tx.sv
`timescale 1ns/1ps
module sim_nine_bit_cmd_tx;
  localparam int HALF = 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [7:0] cmd_count = '0;
  logic par_valid = 1'b0;
  logic [7:0] par_data = '0;
  logic cmd_ready, par_ready, cs_n, sclk, sdo, done;

  always #2 clk = ~clk;

  nine_bit_cmd_tx #(.DATA_W(8), .CNT_W(8), .HALF_DIV(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_code_i(cmd_code), .cmd_count_i(cmd_count),
    .par_valid_i(par_valid), .par_ready_o(par_ready), .par_data_i(par_data),
    .cs_no(cs_n), .sclk_o(sclk), .sdo_o(sdo), .done_o(done)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // serial monitor
  logic [8:0] cap [0:31];
  logic [8:0] mon_sh = '0;
  int ncap = 0, mon_bit = 0, rises = 0, cyc = 0, last_rise = 0;
  int per_min = 0, per_max = 0, sdo_viol = 0, cs_viol = 0, cs_falls = 0;
  logic prev_sclk = 1'b0, prev_sdo = 1'b0, prev_cs = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!cs_n && sclk && !prev_sclk) begin
        rises++;
        if (mon_bit != 0) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        mon_sh = {mon_sh[7:0], sdo};
        mon_bit++;
        if (mon_bit == 9) begin
          if (ncap < 32) cap[ncap] = mon_sh;
          ncap++;
          mon_bit = 0;
        end
      end
      if (sclk && prev_sclk && sdo != prev_sdo) sdo_viol++;
      if (cs_n && mon_bit != 0) cs_viol++;
      if (!cs_n && prev_cs) cs_falls++;
    end
    prev_sclk = sclk;
    prev_sdo  = sdo;
    prev_cs   = cs_n;
  end

  logic [7:0] pbuf [0:15];

  task automatic mon_clear();
    ncap = 0; mon_bit = 0; rises = 0; per_min = 1000000; per_max = 0;
    sdo_viol = 0; cs_viol = 0; cs_falls = 0;
  endtask

  task automatic run_xfer(input logic [7:0] code, input int n, input int stall,
                          input bit poke);
    int stall_bad = 0;
    int busy_rdy = 0;
    logic d_cs = 1'b0, d_sclk = 1'b1, d_rdy = 1'b1, n_done = 1'b1, n_rdy = 1'b0;
    mon_clear();
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_code = code; cmd_count = 8'(n);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_code = ~code; cmd_count = 8'd7;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          do @(negedge clk); while (!par_ready);
          for (int s = 0; s < stall; s++) begin
            if (cs_n || sclk || !par_ready) stall_bad++;
            @(negedge clk);
          end
          @(posedge clk); #1;
          par_valid = 1'b1; par_data = pbuf[i];
          @(posedge clk); #1;
          par_valid = 1'b0; par_data = 8'h00;
        end
      end
      begin
        if (poke) begin
          repeat (600) @(negedge clk);
          busy_rdy = int'(cmd_ready);
          @(posedge clk); #1;
          cmd_valid = 1'b1; cmd_code = 8'hEE; cmd_count = 8'd5;
          repeat (40) @(posedge clk);
          #1 cmd_valid = 1'b0;
        end
      end
      begin
        do @(negedge clk); while (!done);
        d_cs = cs_n; d_sclk = sclk; d_rdy = cmd_ready;
        @(negedge clk);
        n_done = done; n_rdy = cmd_ready;
      end
    join
    chk(ncap == n + 1, "R7 word count", ncap, n + 1);
    if (ncap >= 1) chk(cap[0] == {1'b0, code}, "R2 opcode word", int'(cap[0]), int'({1'b0, code}));
    for (int i = 0; i < n && i + 1 < ncap; i++)
      chk(cap[i+1] == {1'b1, pbuf[i]}, "R3 parameter word", int'(cap[i+1]), int'({1'b1, pbuf[i]}));
    chk(rises == 9 * (n + 1), (n == 0) ? "R4 clock edges" : "R7 clock edges", rises, 9 * (n + 1));
    chk(per_min == 2 * HALF && per_max == 2 * HALF, "R6 bit period",
        (per_min != 2 * HALF) ? per_min : per_max, 2 * HALF);
    chk(sdo_viol == 0, "R5 data stable in high phase", sdo_viol, 0);
    chk(cs_viol == 0 && cs_falls == 1, "R7 single select window", cs_falls, 1);
    chk(d_cs == 1'b1 && d_sclk == 1'b0 && d_rdy == 1'b0, "R9 done alignment",
        int'({d_cs, d_sclk, d_rdy}), 3'b100);
    chk(n_done == 1'b0 && n_rdy == 1'b1, "R9 done width and ready return",
        int'({n_done, n_rdy}), 2'b01);
    if (stall > 0) chk(stall_bad == 0, "R10 stall holds link", stall_bad, 0);
    if (poke) chk(busy_rdy == 0, "R8 ready low while busy", busy_rdy, 0);
    // nothing further may start while idle and undriven
    repeat (3000) @(negedge clk);
    chk(ncap == n + 1 && cs_n == 1'b1 && par_ready == 1'b0, "R8 no extra transaction",
        ncap, n + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 select idle", int'(cs_n), 1);
    chk(sclk == 1'b0 && done == 1'b0, "R1 clock and done idle", int'({sclk, done}), 0);
    chk(cmd_ready == 1'b1 && par_ready == 1'b0, "R1 ready outputs",
        int'({cmd_ready, par_ready}), 2'b10);
  endtask

  task automatic t_no_params();
    run_xfer(8'h29, 0, 0, 1'b0);   // R4
  endtask

  task automatic t_three_params();
    pbuf[0] = 8'h5A; pbuf[1] = 8'hFF; pbuf[2] = 8'h00;
    run_xfer(8'hA5, 3, 0, 1'b0);   // R2 R3
  endtask

  task automatic t_stall();
    pbuf[0] = 8'h81; pbuf[1] = 8'h7E;
    run_xfer(8'hC3, 2, 400, 1'b0); // R10
  endtask

  task automatic t_busy_poke();
    pbuf[0] = 8'h96;
    run_xfer(8'h3C, 1, 0, 1'b1);   // R8
  endtask

  task automatic t_long();
    for (int i = 0; i < 8; i++) pbuf[i] = 8'(i * 8'h1F + 3);
    run_xfer(8'hFF, 8, 0, 1'b0);   // R3 order
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_no_params();
    t_three_params();
    t_stall();
    t_busy_poke();
    t_long();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule